// File: doc/BRIEF.md
# GPIO Interrupt Detect and Aggregate Unit

This block watches the sampled input levels of a bank of general-purpose pins and turns qualifying activity on each pin into a sticky status bit. Every pin is configured with two bits, a level/edge select and a polarity invert. Together they choose between rising-edge, falling-edge, active-low level and active-high level detection. A pin takes part only while it is assigned to general-purpose use and its input sensing is turned on.

Status bits are grouped into 32-bit words, so 95 pins occupy three words. Software clears a status bit by writing a 1 to it. A parallel enable word decides which pending status bits feed the single combined interrupt request. The request is registered and stays asserted while any enabled status bit remains set. The bus side offers a word select, one write strobe for status and one for enable, and combinational readback of the selected status and enable words.

Top module: `gid_irq_aggregator`

## Requirements
- R1: With level select 0 and invert 0 (rising edge), a 0-to-1 change of a pin sets its status bit. The bit then stays set after the pin returns low. A 1-to-0 change does not set it.
- R2: With level select 0 and invert 1 (falling edge), a 1-to-0 change sets the status bit. A 0-to-1 change does not set it.
- R3: With level select 1 and invert 0 (active low), status is set again on every cycle the pin is low. A clear written while the pin stays low has no visible effect, and a clear written after the pin goes high removes the bit. A pin held high sets nothing.
- R4: With level select 1 and invert 1 (active high), a high pin sets status and a pin held low sets nothing.
- R5: A status write clears exactly the bits written as 1 in the selected word. Bits written as 0 keep their value, and writing all ones clears the whole word.
- R6: When a detection sets a status bit in the same cycle that a clear write targets that bit, the bit stays set.
- R7: The request output goes high on the clock edge after a status bit and its enable bit are both set. It goes low on the clock edge after no enabled status bit remains.
- R8: An enable write replaces the selected enable word, and the new value reads back on the next cycle.
- R9: A pin that is not assigned to general-purpose use, or whose input sensing is off, never sets its status bit.
- R10: Pin p maps to bit p mod 32 of word p/32, with word select 0, 1 or 2. Bits above pin 94 always read 0, so an all-ones enable write to word 2 reads back 0x7FFFFFFF. Select value 3 ignores writes and reads 0.
- R11: After reset every status and enable bit is 0 and the request output is low.
- R12: Each pin passes through two synchronising flops. A pin change applied between clock edges shows in status readback after the third rising edge, not the second, and on the request output after the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 95 | Raw pin input levels |
| trig_level | input | 95 | Per pin: 1 selects level detection, 0 selects edge detection |
| trig_inv | input | 95 | Per pin: polarity invert (falling edge or active high) |
| use_gpio | input | 95 | Per pin: 1 when the pin is assigned to general-purpose use |
| sense_en | input | 95 | Per pin: 1 when input sensing is on |
| bus_sel | input | 2 | Word select for writes and readback |
| bus_wr_stat | input | 1 | Write-one-to-clear strobe for the selected status word |
| bus_wr_en | input | 1 | Write strobe for the selected enable word |
| bus_wdata | input | 32 | Write data |
| rd_status | output | 32 | Selected status word |
| rd_enable | output | 32 | Selected enable word |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
Two functions can land on the same bit in the same cycle: a detection setting a status bit and a write-one-to-clear removing it. The bench first latches a pin's bit. It then lets the pin fall and rise again, and times the clear strobe so that it is sampled on exactly the third edge after the new rising edge, which is the edge where the detection lands. The result is judged by readback. The bit must still be set, and a second clear with no detection pending must then remove it.

// File: rtl/gid_pkg.sv
package gid_pkg;

   // Encoding is {level_select, invert}; the detector decodes it per pin.
   typedef enum logic [1:0] {
      TRIG_RISE = 2'b00,
      TRIG_FALL = 2'b01,
      TRIG_LOW  = 2'b10,
      TRIG_HIGH = 2'b11
   } trig_mode_e;

   function automatic trig_mode_e mode_of(input logic lvl, input logic inv);
      return trig_mode_e'({lvl, inv});
   endfunction

endpackage

// File: rtl/gid_sync.sv
module gid_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gid_detect.sv
module gid_detect
   import gid_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cur_i,
   input  logic [WIDTH-1:0] lvl_i,
   input  logic [WIDTH-1:0] inv_i,
   input  logic [WIDTH-1:0] qual_i,
   output logic [WIDTH-1:0] evt_o
);

   // Last synchronised level; tracked regardless of qualification so that
   // enabling sensing on a steady pin never fakes an edge.
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cur_i;
   end

   for (genvar p = 0; p < WIDTH; p++) begin : g_pin
      logic hit;
      always_comb begin
         case (mode_of(lvl_i[p], inv_i[p]))
            TRIG_RISE: hit = cur_i[p] & ~prev_q[p];
            TRIG_FALL: hit = ~cur_i[p] & prev_q[p];
            TRIG_LOW:  hit = ~cur_i[p];
            TRIG_HIGH: hit = cur_i[p];
            default:   hit = 1'b0;
         endcase
      end
      assign evt_o[p] = hit & qual_i[p];
   end

endmodule

// File: rtl/gid_status_word.sv
module gid_status_word #(
   parameter int WORD_W     = 32,
   parameter int VALID_BITS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] set_i,
   input  logic              wr_stat_i,
   input  logic              wr_en_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic [WORD_W-1:0] stat_o,
   output logic [WORD_W-1:0] en_o,
   output logic              pend_o
);

   localparam logic [WORD_W-1:0] VMASK = (VALID_BITS >= WORD_W) ? {WORD_W{1'b1}}
                                        : WORD_W'((64'd1 << VALID_BITS) - 64'd1);

   logic [WORD_W-1:0] stat_q, en_q, clr;

   assign clr = wr_stat_i ? wdata_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         en_q   <= '0;
      end else begin
         // Set term is OR-ed after the clear so a same-cycle detection wins.
         stat_q <= ((stat_q & ~clr) | set_i) & VMASK;
         if (wr_en_i) en_q <= wdata_i & VMASK;
      end
   end

   assign stat_o = stat_q;
   assign en_o   = en_q;
   assign pend_o = |(stat_q & en_q);

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat_i && ((wdata_i & set_i) == '0)) |=> ((stat_o & $past(wdata_i)) == '0)); // R5

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((stat_o & $past(set_i)) == $past(set_i))); // R6

   AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (en_o == ($past(wdata_i) & VMASK))); // R8

   AST_PAD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en_i) |-> (((stat_o | en_o) & ~VMASK) == '0)); // R10

endmodule

// File: rtl/gid_irq_aggregator.sv
module gid_irq_aggregator #(
   parameter int NUM_PINS    = 95,
   parameter int WORD_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic [NUM_PINS-1:0] trig_level,
   input  logic [NUM_PINS-1:0] trig_inv,
   input  logic [NUM_PINS-1:0] use_gpio,
   input  logic [NUM_PINS-1:0] sense_en,
   input  logic [1:0]          bus_sel,
   input  logic                bus_wr_stat,
   input  logic                bus_wr_en,
   input  logic [WORD_W-1:0]   bus_wdata,
   output logic [WORD_W-1:0]   rd_status,
   output logic [WORD_W-1:0]   rd_enable,
   output logic                irq_o
);

   localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;
   localparam int PAD_W     = NUM_WORDS * WORD_W;

   if (NUM_PINS < 1 || WORD_W < 1 || WORD_W > 64 || SYNC_STAGES < 2 || NUM_WORDS > 4)
   begin : g_bad_params
      $error("gid_irq_aggregator: unsupported parameter set");
   end

   logic [NUM_PINS-1:0]  pin_sync, qual, evt;
   logic [PAD_W-1:0]     evt_pad, stat_all, en_all;
   logic [NUM_WORDS-1:0] pend;
   logic                 irq_q;

   assign qual = use_gpio & sense_en;

   gid_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_in),
      .q_o   (pin_sync)
   );

   gid_detect #(.WIDTH(NUM_PINS)) u_detect (
      .clk    (clk),
      .rst_n  (rst_n),
      .cur_i  (pin_sync),
      .lvl_i  (trig_level),
      .inv_i  (trig_inv),
      .qual_i (qual),
      .evt_o  (evt)
   );

   assign evt_pad = PAD_W'(evt);

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      localparam int VB = ((NUM_PINS - w * WORD_W) >= WORD_W) ? WORD_W
                        : (NUM_PINS - w * WORD_W);
      logic hit;
      assign hit = (bus_sel == 2'(w));

      gid_status_word #(.WORD_W(WORD_W), .VALID_BITS(VB)) u_word (
         .clk       (clk),
         .rst_n     (rst_n),
         .set_i     (evt_pad[w*WORD_W +: WORD_W]),
         .wr_stat_i (bus_wr_stat & hit),
         .wr_en_i   (bus_wr_en & hit),
         .wdata_i   (bus_wdata),
         .stat_o    (stat_all[w*WORD_W +: WORD_W]),
         .en_o      (en_all[w*WORD_W +: WORD_W]),
         .pend_o    (pend[w])
      );
   end

   always_comb begin
      rd_status = '0;
      rd_enable = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (bus_sel == 2'(w)) begin
            rd_status = stat_all[w*WORD_W +: WORD_W];
            rd_enable = en_all[w*WORD_W +: WORD_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |pend;
   end

   assign irq_o = irq_q;

   AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
      (|(stat_all & en_all)) |=> irq_o); // R7

   AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(stat_all & en_all)) |=> !irq_o); // R7

   AST_UNQUALIFIED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_all[NUM_PINS-1:0] & ~$past(stat_all[NUM_PINS-1:0]) & ~$past(qual)) == '0)); // R9

endmodule

// File: tb/tb_gid_irq_aggregator.sv
module tb_gid_irq_aggregator;

   localparam int NP = 95;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pin_in = '0, trig_level = '0, trig_inv = '0;
   logic [NP-1:0] use_gpio = '1, sense_en = '0;
   logic [1:0]    bus_sel = '0;
   logic          bus_wr_stat = 1'b0, bus_wr_en = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   rd_status, rd_enable;
   logic          irq_o;

   int nvec = 0;
   int nbad = 0;

   always #2 clk = ~clk;

   gid_irq_aggregator dut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .trig_level(trig_level),
      .trig_inv(trig_inv), .use_gpio(use_gpio), .sense_en(sense_en),
      .bus_sel(bus_sel), .bus_wr_stat(bus_wr_stat), .bus_wr_en(bus_wr_en),
      .bus_wdata(bus_wdata), .rd_status(rd_status), .rd_enable(rd_enable),
      .irq_o(irq_o)
   );

   // {pin[6:0], level_sel, invert, start level, new level, expected status}
   localparam logic [11:0] VEC [9] = '{
      {7'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
      {7'd33, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
      {7'd64, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
      {7'd94, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
      {7'd5,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
      {7'd40, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
      {7'd70, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
      {7'd31, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
      {7'd63, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic bus_write(input bit to_stat, input int sel, input logic [31:0] d);
      bus_sel     = 2'(sel);
      bus_wdata   = d;
      bus_wr_stat = to_stat;
      bus_wr_en   = !to_stat;
      @(posedge clk);
      @(negedge clk);
      bus_wr_stat = 1'b0;
      bus_wr_en   = 1'b0;
   endtask

   task automatic read_word(input int sel, output logic [31:0] st, output logic [31:0] en);
      bus_sel = 2'(sel);
      #1;
      st = rd_status;
      en = rd_enable;
   endtask

   task automatic clear_all();
      for (int w = 0; w < 3; w++) bus_write(1'b1, w, 32'hFFFF_FFFF);
   endtask

   task automatic quiet_all();
      sense_en   = '0;
      trig_level = '0;
      trig_inv   = '0;
      use_gpio   = '1;
      settle(6);
      clear_all();
   endtask

   initial begin
      #(200000 * 4);
      nbad++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      logic [31:0] st, en;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: reset state
      check("R11 irq", {31'd0, irq_o}, 32'd0);
      for (int w = 0; w < 3; w++) begin
         read_word(w, st, en);
         check("R11 status", st, 32'd0);
         check("R11 enable", en, 32'd0);
      end

      // Table walk: R1..R4 trigger modes
      for (int i = 0; i < 9; i++) begin
         int p;
         logic lv, iv;
         string tag;
         p  = int'(VEC[i][11:5]);
         lv = VEC[i][4];
         iv = VEC[i][3];
         case ({lv, iv})
            2'b00:   tag = "R1 rising";
            2'b01:   tag = "R2 falling";
            2'b10:   tag = "R3 level-low";
            default: tag = "R4 level-high";
         endcase
         sense_en      = '0;
         trig_level[p] = lv;
         trig_inv[p]   = iv;
         pin_in[p]     = VEC[i][2];
         sense_en[p]   = 1'b1;
         settle(6);
         clear_all();
         pin_in[p] = VEC[i][1];
         settle(6);
         read_word(p / 32, st, en);
         check(tag, st, VEC[i][0] ? (32'd1 << (p % 32)) : 32'd0);
      end

      quiet_all();
      pin_in = '0;
      settle(4);
      clear_all();

      // R12 / R7: latency through synchroniser, status and request register
      sense_en[10] = 1'b1;
      bus_write(1'b0, 0, 32'h0000_0400);
      pin_in[10] = 1'b1;
      settle(2);
      read_word(0, st, en);
      check("R12 status after two edges", st, 32'd0);
      settle(1);
      read_word(0, st, en);
      check("R12 status after three edges", st, 32'h0000_0400);
      check("R12 irq after three edges", {31'd0, irq_o}, 32'd0);
      settle(1);
      check("R7 irq after four edges", {31'd0, irq_o}, 32'd1);

      // R7: masking the pending bit drops the request one edge later
      bus_write(1'b0, 0, 32'd0);
      check("R7 irq held one edge after mask", {31'd0, irq_o}, 32'd1);
      settle(1);
      check("R7 irq after mask", {31'd0, irq_o}, 32'd0);
      bus_write(1'b0, 0, 32'h0000_0400);
      settle(1);
      check("R7 irq after unmask", {31'd0, irq_o}, 32'd1);
      bus_write(1'b1, 0, 32'h0000_0400);
      settle(1);
      check("R7 irq after clear", {31'd0, irq_o}, 32'd0);

      // R6: detection and clear on the same edge
      pin_in[10] = 1'b0;
      settle(4);
      pin_in[10] = 1'b1;
      settle(4);
      pin_in[10] = 1'b0;
      settle(4);
      read_word(0, st, en);
      check("R1 latched after pin low", st, 32'h0000_0400);
      pin_in[10] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      bus_sel     = 2'd0;
      bus_wdata   = 32'h0000_0400;
      bus_wr_stat = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr_stat = 1'b0;
      read_word(0, st, en);
      check("R6 set wins over clear", st, 32'h0000_0400);
      bus_write(1'b1, 0, 32'h0000_0400);
      read_word(0, st, en);
      check("R5 clear with no detection", st, 32'd0);

      // R5: partial clears
      bus_write(1'b0, 0, 32'd0);
      sense_en[1] = 1'b1;
      sense_en[2] = 1'b1;
      pin_in[1]   = 1'b1;
      pin_in[2]   = 1'b1;
      settle(4);
      bus_write(1'b1, 0, 32'd0);
      read_word(0, st, en);
      check("R5 zero write keeps", st, 32'h0000_0006);
      bus_write(1'b1, 0, 32'h0000_0002);
      read_word(0, st, en);
      check("R5 single-bit clear", st, 32'h0000_0004);
      bus_write(1'b1, 0, 32'hFFFF_FFFF);
      read_word(0, st, en);
      check("R5 all-ones clear", st, 32'd0);

      // R3: clear ineffective while the low level persists
      trig_level[3] = 1'b1;
      sense_en[3]   = 1'b1;
      settle(4);
      bus_write(1'b1, 0, 32'h0000_0008);
      read_word(0, st, en);
      check("R3 clear while low", st, 32'h0000_0008);
      pin_in[3] = 1'b1;
      settle(4);
      bus_write(1'b1, 0, 32'h0000_0008);
      read_word(0, st, en);
      check("R3 clear after high", st, 32'd0);

      // R9: unqualified pins
      use_gpio[20] = 1'b0;
      sense_en[20] = 1'b1;
      sense_en[21] = 1'b0;
      pin_in[20]   = 1'b1;
      pin_in[21]   = 1'b1;
      settle(5);
      read_word(0, st, en);
      check("R9 non-GPIO and sensing-off pins", st & 32'h0030_0000, 32'd0);

      // R8 / R10: enable readback, word mapping, padding, out-of-range select
      bus_write(1'b0, 2, 32'hFFFF_FFFF);
      read_word(2, st, en);
      check("R10 word2 enable padding", en, 32'h7FFF_FFFF);
      bus_write(1'b0, 1, 32'hA5A5_0F0F);
      read_word(1, st, en);
      check("R8 enable word1 readback", en, 32'hA5A5_0F0F);
      trig_level[94] = 1'b1;
      trig_inv[94]   = 1'b1;
      sense_en[94]   = 1'b1;
      pin_in[94]     = 1'b1;
      settle(4);
      read_word(2, st, en);
      check("R10 pin 94 in word2 bit30", st, 32'h4000_0000);
      bus_write(1'b0, 3, 32'hFFFF_FFFF);
      read_word(1, st, en);
      check("R10 select 3 write ignored", en, 32'hA5A5_0F0F);
      read_word(3, st, en);
      check("R10 select 3 reads zero", st | en, 32'd0);

      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule